// File: doc/BRIEF.md
# Four-Channel Block-Transfer DMA Engine

This block moves data between peripherals and memory without the processor touching each byte. Software first programs it through a byte-wide register port. Each of the four channels has a start address and a count word, and a shared enable register switches channels on. When an enabled peripheral raises its request line, the engine asks the processor for the buses with a hold request. It takes the buses only once the hold is acknowledged. It then runs transfers for the winning channel until no enabled request is left.

Each transfer takes two clock cycles. In the first cycle the engine puts the upper address byte on its data output with a strobe, so that an external latch can capture it, and drives the lower byte on its own address lines. In the second cycle it drives the memory and I/O strobes that the channel's transfer type calls for. The peripheral being served sees its own active-low acknowledge during both cycles. A terminal-count output marks the final transfer of a block, and a mark output flags every 128th transfer.

Top module: `dma4_engine`

## Requirements
- R1: After reset all four channel enables read as 0, the byte-order flip-flop points at the low byte, hrq, aen, adstb, tc and mark are 0, and dack_n and all four strobes are high.
- R2: With a_sel[3]=0, a_sel[2:1] picks a channel and a_sel[0] picks its address (0) or count word (1). Each write or read of one of these moves the byte-order flip-flop, so accesses alternate low byte then high byte. With a_sel[3]=1 the access goes to the enable register, whose bits [3:0] are the channel enables; a write to it returns the flip-flop to the low byte.
- R3: In the count word, bits [13:0] hold N and the block length is N+1 transfers. Bits [15:14] hold the type: 00 verify, 01 write (I/O to memory), 10 read (memory to I/O), and 11 behaves as verify.
- R4: A request on a channel whose enable is 0 is ignored. A request on an enabled channel raises hrq. aen, adstb and the strobes stay inactive until hlda is high. hrq falls once no enabled request remains.
- R5: When several enabled channels request, the lowest-numbered one is served. Arbitration is repeated before every transfer, so a higher-priority request can cut into a running block.
- R6: Each transfer is an address cycle followed by a transfer cycle. During the address cycle aen=1, adstb=1, db_oe=1, db_out carries address bits [15:8], and addr_lo carries bits [7:0], which are held through the transfer cycle. After each transfer the channel address goes up by 1 and N goes down by 1.
- R7: In its transfer cycle, a read asserts memr_n and iow_n low, a write asserts memw_n and ior_n low, and a verify asserts no strobe. dack_n is low only for the channel being served, and only in its two cycles.
- R8: tc is high in the transfer cycle when the channel's N is 0. After that transfer the channel's enable bit reads 0.
- R9: mark is high during the transfer cycle of the 128th, 256th, and every later multiple of 128 transfers counted since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Register port select, active low |
| a_sel | input | 4 | Register select |
| rd_n | input | 1 | Register read strobe, active low |
| wr_n | input | 1 | Register write strobe, active low |
| db_in | input | 8 | Register write data |
| db_out | output | 8 | Read data, or upper address byte in the address cycle |
| db_oe | output | 1 | db_out is being driven |
| dreq | input | 4 | Peripheral requests, one per channel |
| dack_n | output | 4 | Per-channel acknowledge, active low |
| hrq | output | 1 | Hold request to the processor |
| hlda | input | 1 | Hold acknowledge from the processor |
| addr_lo | output | 8 | Lower address byte |
| aen | output | 1 | Engine owns the buses |
| adstb | output | 1 | Upper address byte strobe |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| tc | output | 1 | Last transfer of a block |
| mark | output | 1 | Every 128th transfer |

## Verification
The tests cover the following patterns:
- A single read block whose addresses cross a 256-byte boundary. This shows whether the latched upper byte tracks the carry out of the lower byte.
- Three channels that raise requests at the same time, with mixed types. This separates the priority order from the strobe selection for each type.
- A low-priority block that is running when channel 0 starts requesting. This shows whether the engine arbitrates again before each transfer or only once per block.
- A request on a disabled channel, and a request with the hold grant held off. These show that neither one reaches the bus.
- A long block of the spare type, which confirms the mark spacing.
- An address write that is interrupted by an enable write, which shows the byte-order reset.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  typedef enum logic [1:0] {
    XT_VERIFY = 2'b00,
    XT_WRITE  = 2'b01,
    XT_READ   = 2'b10,
    XT_SPARE  = 2'b11
  } xfer_kind_e;

  typedef enum logic [1:0] {
    MS_IDLE,
    MS_WAIT,
    MS_ADDR,
    MS_XFER
  } mstate_e;
endpackage

// File: rtl/dma4_prio_arb.sv
module dma4_prio_arb #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [CHW-1:0] idx
);
  // Lowest index wins: scan from the top so the last hit is the smallest.
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = CHW'(i);
    end
  end
endmodule

// File: rtl/dma4_chan_regs.sv
module dma4_chan_regs #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 14,
  localparam int CHW  = $clog2(NCH),
  localparam int SELW = CHW + 2,
  localparam int WW   = CW + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_wr,
  input  logic                     acc_rd_done,
  input  logic [SELW-1:0]          sel,
  input  logic [7:0]               wdata,
  output logic [7:0]               rdata,
  input  logic                     upd,
  input  logic [CHW-1:0]           upd_ch,
  output logic [NCH-1:0]           en_o,
  output logic [NCH-1:0][AW-1:0]   addr_o,
  output logic [NCH-1:0][CW-1:0]   cnt_o,
  output logic [NCH-1:0][1:0]      kind_o
);
  logic [NCH-1:0][AW-1:0] addr_q, addr_d;
  logic [NCH-1:0][WW-1:0] word_q, word_d;
  logic [NCH-1:0]         en_q, en_d;
  logic                   ff_q, ff_d;

  logic           is_mode;
  logic           is_word;
  logic [CHW-1:0] ch;

  assign is_mode = sel[SELW-1];
  assign is_word = sel[0];
  assign ch      = sel[CHW:1];

  always_comb begin
    addr_d = addr_q;
    word_d = word_q;
    en_d   = en_q;
    ff_d   = ff_q;
    if (upd) begin
      addr_d[upd_ch]         = addr_q[upd_ch] + AW'(1);
      word_d[upd_ch][CW-1:0] = word_q[upd_ch][CW-1:0] - CW'(1);
      if (word_q[upd_ch][CW-1:0] == '0) en_d[upd_ch] = 1'b0;
    end else if (acc_wr) begin
      if (is_mode) begin
        en_d = wdata[NCH-1:0];
        ff_d = 1'b0;
      end else begin
        if (is_word) begin
          if (ff_q) word_d[ch][WW-1:8] = wdata[WW-9:0];
          else      word_d[ch][7:0]    = wdata;
        end else begin
          if (ff_q) addr_d[ch][AW-1:8] = wdata[AW-9:0];
          else      addr_d[ch][7:0]    = wdata;
        end
        ff_d = ~ff_q;
      end
    end else if (acc_rd_done && !is_mode) begin
      ff_d = ~ff_q;
    end
  end

  always_comb begin
    if (is_mode)      rdata = {{(8-NCH){1'b0}}, en_q};
    else if (is_word) rdata = ff_q ? word_q[ch][WW-1:8] : word_q[ch][7:0];
    else              rdata = ff_q ? addr_q[ch][AW-1:8] : addr_q[ch][7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      word_q <= '0;
      en_q   <= '0;
      ff_q   <= 1'b0;
    end else begin
      addr_q <= addr_d;
      word_q <= word_d;
      en_q   <= en_d;
      ff_q   <= ff_d;
    end
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_out
      assign addr_o[g] = addr_q[g];
      assign cnt_o[g]  = word_q[g][CW-1:0];
      assign kind_o[g] = word_q[g][WW-1:CW];
    end
  endgenerate
  assign en_o = en_q;
endmodule

// File: rtl/dma4_master_fsm.sv
module dma4_master_fsm
  import dma4_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int AW          = 16,
  parameter int CW          = 14,
  parameter int MARK_PERIOD = 128,
  localparam int CHW = $clog2(NCH),
  localparam int MW  = $clog2(MARK_PERIOD)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         dreq,
  input  logic [NCH-1:0]         en,
  input  logic                   hlda,
  input  logic [NCH-1:0][AW-1:0] addr_all,
  input  logic [NCH-1:0][CW-1:0] cnt_all,
  input  logic [NCH-1:0][1:0]    kind_all,
  output logic                   hrq,
  output logic                   aen,
  output logic                   adstb,
  output logic [AW-1:0]          cur_addr,
  output logic [NCH-1:0]         dack_n,
  output logic                   memr_n,
  output logic                   memw_n,
  output logic                   ior_n,
  output logic                   iow_n,
  output logic                   tc,
  output logic                   mark,
  output logic                   upd,
  output logic [CHW-1:0]         upd_ch
);
  mstate_e        state_q, state_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic [MW-1:0]  mcnt_q, mcnt_d;

  logic           in_xfer;
  logic           tc_now;
  logic [NCH-1:0] clr_mask;
  logic [NCH-1:0] req_v;
  logic           any;
  logic [CHW-1:0] win;
  xfer_kind_e     kind;

  assign in_xfer  = (state_q == MS_XFER);
  assign tc_now   = in_xfer && (cnt_all[ch_q] == '0);
  assign clr_mask = tc_now ? (NCH'(1) << ch_q) : '0;
  assign req_v    = dreq & en & ~clr_mask;
  assign kind     = xfer_kind_e'(kind_all[ch_q]);

  dma4_prio_arb #(.NCH(NCH)) u_arb (
    .req (req_v),
    .any (any),
    .idx (win)
  );

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    case (state_q)
      MS_IDLE: if (any) state_d = MS_WAIT;
      MS_WAIT: begin
        if (!any) state_d = MS_IDLE;
        else if (hlda) begin
          state_d = MS_ADDR;
          ch_d    = win;
        end
      end
      MS_ADDR: state_d = MS_XFER;
      MS_XFER: begin
        if (hlda && any) begin
          state_d = MS_ADDR;
          ch_d    = win;
        end else begin
          state_d = MS_IDLE;
        end
      end
      default: state_d = MS_IDLE;
    endcase
  end

  always_comb begin
    mcnt_d = mcnt_q;
    if (in_xfer) begin
      if (mcnt_q == MW'(MARK_PERIOD - 1)) mcnt_d = '0;
      else                                mcnt_d = mcnt_q + MW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      ch_q    <= '0;
      mcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      mcnt_q  <= mcnt_d;
    end
  end

  assign hrq      = (state_q != MS_IDLE);
  assign aen      = (state_q == MS_ADDR) || in_xfer;
  assign adstb    = (state_q == MS_ADDR);
  assign cur_addr = addr_all[ch_q];
  assign dack_n   = aen ? ~(NCH'(1) << ch_q) : '1;
  assign memr_n   = !(in_xfer && kind == XT_READ);
  assign iow_n    = !(in_xfer && kind == XT_READ);
  assign memw_n   = !(in_xfer && kind == XT_WRITE);
  assign ior_n    = !(in_xfer && kind == XT_WRITE);
  assign tc       = tc_now;
  assign mark     = in_xfer && (mcnt_q == MW'(MARK_PERIOD - 1));
  assign upd      = in_xfer;
  assign upd_ch   = ch_q;
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine #(
  parameter int NCH         = 4,
  parameter int AW          = 16,
  parameter int CW          = 14,
  parameter int MARK_PERIOD = 128,
  localparam int CHW  = $clog2(NCH),
  localparam int SELW = CHW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic [SELW-1:0] a_sel,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic [7:0]      db_in,
  output logic [7:0]      db_out,
  output logic            db_oe,
  input  logic [NCH-1:0]  dreq,
  output logic [NCH-1:0]  dack_n,
  output logic            hrq,
  input  logic            hlda,
  output logic [7:0]      addr_lo,
  output logic            aen,
  output logic            adstb,
  output logic            memr_n,
  output logic            memw_n,
  output logic            ior_n,
  output logic            iow_n,
  output logic            tc,
  output logic            mark
);
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  logic wr_on, rd_on, wr_q, rd_q;
  logic acc_wr, acc_rd_done;

  // The register port is locked out while the engine owns the buses.
  assign wr_on = !cs_n && !wr_n && !aen;
  assign rd_on = !cs_n && !rd_n && !aen;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_on;
      rd_q <= rd_on;
    end
  end
  assign acc_wr      = wr_on && !wr_q;
  assign acc_rd_done = rd_q && !rd_on;

  logic [7:0]               rdata;
  logic                     upd;
  logic [CHW-1:0]           upd_ch;
  logic [NCH-1:0]           en;
  logic [NCH-1:0][AW-1:0]   addr_all;
  logic [NCH-1:0][CW-1:0]   cnt_all;
  logic [NCH-1:0][1:0]      kind_all;
  logic [AW-1:0]            cur_addr;

  dma4_chan_regs #(.NCH(NCH), .AW(AW), .CW(CW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .acc_wr      (acc_wr),
    .acc_rd_done (acc_rd_done),
    .sel         (a_sel),
    .wdata       (db_in),
    .rdata       (rdata),
    .upd         (upd),
    .upd_ch      (upd_ch),
    .en_o        (en),
    .addr_o      (addr_all),
    .cnt_o       (cnt_all),
    .kind_o      (kind_all)
  );

  dma4_master_fsm #(.NCH(NCH), .AW(AW), .CW(CW), .MARK_PERIOD(MARK_PERIOD)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .dreq     (dreq),
    .en       (en),
    .hlda     (hlda),
    .addr_all (addr_all),
    .cnt_all  (cnt_all),
    .kind_all (kind_all),
    .hrq      (hrq),
    .aen      (aen),
    .adstb    (adstb),
    .cur_addr (cur_addr),
    .dack_n   (dack_n),
    .memr_n   (memr_n),
    .memw_n   (memw_n),
    .ior_n    (ior_n),
    .iow_n    (iow_n),
    .tc       (tc),
    .mark     (mark),
    .upd      (upd),
    .upd_ch   (upd_ch)
  );

  assign db_out  = adstb ? cur_addr[AW-1:8] : rdata;
  assign db_oe   = adstb || rd_on;
  assign addr_lo = aen ? cur_addr[7:0] : 8'h00;
endmodule

// File: rtl/dma4_engine_chk.sv
module dma4_engine_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] dack_n,
  input logic           hrq,
  input logic           hlda,
  input logic           aen,
  input logic           adstb,
  input logic           db_oe,
  input logic           memr_n,
  input logic           memw_n,
  input logic           ior_n,
  input logic           iow_n,
  input logic           tc,
  input logic           mark
);
  logic any_strobe;
  assign any_strobe = !memr_n || !memw_n || !ior_n || !iow_n;

  AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dack_n)) else $error("dack_n not one-hot");  // R7

  AST_STROBE_HAS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |-> (aen && hrq && !adstb)) else $error("strobe without bus");  // R4

  AST_AEN_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aen) |-> (hrq && $past(hlda))) else $error("bus taken without grant");  // R4

  AST_ADSTB_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    adstb |-> (aen && db_oe && !any_strobe)) else $error("address cycle malformed");  // R6

  AST_ADDR_THEN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    adstb |=> (aen && !adstb && $stable(dack_n))) else $error("transfer cycle missing");  // R6

  AST_NO_DUAL_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !(!memr_n && !memw_n)) else $error("both memory strobes");  // R7

  AST_TC_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (aen && !adstb && (dack_n != '1))) else $error("tc outside transfer");  // R8

  AST_MARK_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    mark |-> (aen && !adstb)) else $error("mark outside transfer");  // R9
endmodule

bind dma4_engine dma4_engine_chk #(.NCH(NCH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .dack_n (dack_n),
  .hrq    (hrq),
  .hlda   (hlda),
  .aen    (aen),
  .adstb  (adstb),
  .db_oe  (db_oe),
  .memr_n (memr_n),
  .memw_n (memw_n),
  .ior_n  (ior_n),
  .iow_n  (iow_n),
  .tc     (tc),
  .mark   (mark)
);

// File: tb/dma4_engine_tb.sv
`timescale 1ns/1ps
module dma4_engine_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, rd_n, wr_n;
  logic [3:0] a_sel;
  logic [7:0] db_in;
  logic [7:0] db_out;
  logic       db_oe;
  logic [3:0] dreq;
  logic [3:0] dack_n;
  logic       hrq, hlda;
  logic [7:0] addr_lo;
  logic       aen, adstb, memr_n, memw_n, ior_n, iow_n, tc, mark;

  always #4 clk = ~clk;

  dma4_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .a_sel(a_sel), .rd_n(rd_n), .wr_n(wr_n),
    .db_in(db_in), .db_out(db_out), .db_oe(db_oe), .dreq(dreq), .dack_n(dack_n),
    .hrq(hrq), .hlda(hlda), .addr_lo(addr_lo), .aen(aen), .adstb(adstb),
    .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n), .tc(tc), .mark(mark)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // Monitor: transfer log, processor hold model and peripheral request drop.
  int         nlog;
  int         lg_ch   [256];
  logic [15:0] lg_addr[256];
  logic [3:0] lg_strb [256];
  logic       lg_tc   [256];
  int         gtotal = 0;
  int         mark_err = 0;
  int         mark_seen = 0;
  int         strb_seen = 0;
  int         aen_seen = 0;
  int         hrq_seen = 0;
  bit         grant_en = 1;
  logic [7:0] hi_lat = 8'h00;

  initial begin
    hlda = 1'b0;
    forever begin
      @(negedge clk);
      hlda = grant_en ? hrq : 1'b0;
      if (hrq) hrq_seen++;
      if (aen) aen_seen++;
      if (aen && adstb) hi_lat = db_out;
      else if (aen) begin
        int ch = 0;
        for (int i = 0; i < 4; i++) if (!dack_n[i]) ch = i;
        if (nlog < 256) begin
          lg_ch[nlog]   = ch;
          lg_addr[nlog] = {hi_lat, addr_lo};
          lg_strb[nlog] = {!memr_n, !memw_n, !ior_n, !iow_n};
          lg_tc[nlog]   = tc;
        end
        if (!memr_n || !memw_n || !ior_n || !iow_n) strb_seen++;
        if (mark !== ((gtotal % 128) == 127)) mark_err++;
        if (mark) mark_seen++;
        nlog++;
        gtotal++;
        if (tc) dreq[ch] = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk);
    cs_n = 0; a_sel = sel; db_in = d; wr_n = 0;
    @(negedge clk);
    wr_n = 1; cs_n = 1;
    @(negedge clk);
  endtask

  task automatic reg_read(input logic [3:0] sel, output logic [7:0] d);
    @(negedge clk);
    cs_n = 0; a_sel = sel; rd_n = 0;
    @(negedge clk);
    d = db_out;
    rd_n = 1; cs_n = 1;
    @(negedge clk);
  endtask

  task automatic write16(input logic [3:0] sel, input logic [15:0] v);
    reg_write(sel, v[7:0]);
    reg_write(sel, v[15:8]);
  endtask

  task automatic read16(input logic [3:0] sel, output logic [15:0] v);
    logic [7:0] lo, hi;
    reg_read(sel, lo);
    reg_read(sel, hi);
    v = {hi, lo};
  endtask

  task automatic wait_done(input int n);
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (nlog >= n && !hrq) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] m;
    chk("R1 hrq", hrq, 0);
    chk("R1 aen", aen, 0);
    chk("R1 dack_n", dack_n, 4'hF);
    chk("R1 strobes", {memr_n, memw_n, ior_n, iow_n, tc, mark, adstb}, 7'b1111000);
    reg_read(4'b1000, m);
    chk("R1 enables", m, 8'h00);
  endtask

  task automatic t_read_block();
    logic [15:0] v;
    logic [7:0]  m;
    nlog = 0;
    write16(4'b0010, 16'h12FE);
    write16(4'b0011, 16'h8002);
    reg_write(4'b1000, 8'h02);
    dreq = 4'b0010;
    wait_done(3);
    chk("R3 block length", nlog, 3);
    chk("R6 addr0", lg_addr[0], 16'h12FE);
    chk("R6 addr1", lg_addr[1], 16'h12FF);
    chk("R6 addr2 carry", lg_addr[2], 16'h1300);
    chk("R7 read strobes", {lg_strb[0], lg_strb[2]}, 8'b1001_1001);
    chk("R7 dack channel", lg_ch[1], 1);
    chk("R8 tc last only", {lg_tc[0], lg_tc[1], lg_tc[2]}, 3'b001);
    chk("R4 hrq dropped", hrq, 0);
    read16(4'b0010, v);
    chk("R6 addr readback", v, 16'h1301);
    read16(4'b0011, v);
    chk("R2 count readback", v, 16'hBFFF);
    reg_read(4'b1000, m);
    chk("R8 enable cleared", m, 8'h00);
  endtask

  task automatic t_priority();
    nlog = 0;
    write16(4'b0000, 16'h0040);
    write16(4'b0001, 16'h4000);
    write16(4'b0100, 16'h2000);
    write16(4'b0101, 16'h0001);
    write16(4'b0110, 16'h3000);
    write16(4'b0111, 16'h4000);
    reg_write(4'b1000, 8'h0D);
    dreq = 4'b1101;
    wait_done(4);
    chk("R5 count", nlog, 4);
    chk("R5 order", {4'(lg_ch[0]), 4'(lg_ch[1]), 4'(lg_ch[2]), 4'(lg_ch[3])}, 16'h0223);
    chk("R7 write strobes", lg_strb[0], 4'b0110);
    chk("R7 verify silent", {lg_strb[1], lg_strb[2]}, 8'h00);
    chk("R6 ch2 addr", {lg_addr[1], lg_addr[2]}, 32'h2000_2001);
    chk("R8 tc pattern", {lg_tc[0], lg_tc[1], lg_tc[2], lg_tc[3]}, 4'b1011);
  endtask

  task automatic t_disabled();
    nlog = 0;
    hrq_seen = 0;
    dreq = 4'b1000;
    repeat (20) @(negedge clk);
    chk("R4 disabled no hrq", hrq_seen, 0);
    chk("R4 disabled no xfer", nlog, 0);
    dreq = 4'b0000;
  endtask

  task automatic t_hold_gate();
    nlog = 0;
    aen_seen = 0;
    grant_en = 0;
    write16(4'b0000, 16'h0500);
    write16(4'b0001, 16'h8000);
    reg_write(4'b1000, 8'h01);
    dreq = 4'b0001;
    repeat (20) @(negedge clk);
    chk("R4 hrq waits", hrq, 1);
    chk("R4 no bus before grant", aen_seen, 0);
    grant_en = 1;
    wait_done(1);
    chk("R4 one transfer after grant", nlog, 1);
    chk("R6 gated addr", lg_addr[0], 16'h0500);
  endtask

  task automatic t_preempt();
    int pos = -1;
    int nz = 0;
    int k3 = 0;
    bit seq_ok = 1;
    nlog = 0;
    write16(4'b0110, 16'h4000);
    write16(4'b0111, 16'h0005);
    write16(4'b0000, 16'h5000);
    write16(4'b0001, 16'h0000);
    reg_write(4'b1000, 8'h09);
    dreq = 4'b1000;
    while (nlog < 2) @(negedge clk);
    dreq[0] = 1'b1;
    wait_done(7);
    chk("R5 preempt total", nlog, 7);
    for (int i = 0; i < 7; i++) begin
      if (lg_ch[i] == 0) begin pos = i; nz++; end
      else begin
        if (lg_addr[i] != 16'h4000 + 16'(k3)) seq_ok = 0;
        k3++;
      end
    end
    chk("R5 ch0 once", nz, 1);
    chk("R5 ch0 cut in", (pos == 2 || pos == 3), 1);
    chk("R6 ch3 sequence kept", seq_ok, 1);
  endtask

  task automatic t_mark();
    int base = gtotal;
    int exp_marks = 0;
    nlog = 0;
    mark_err = 0;
    mark_seen = 0;
    strb_seen = 0;
    for (int i = base; i < base + 300; i++) if ((i % 128) == 127) exp_marks++;
    write16(4'b0010, 16'h7000);
    write16(4'b0011, 16'hC12B);
    reg_write(4'b1000, 8'h02);
    dreq = 4'b0010;
    wait_done(300);
    chk("R3 long block length", nlog, 300);
    chk("R3 spare type silent", strb_seen, 0);
    chk("R9 mark placement", mark_err, 0);
    chk("R9 mark count", mark_seen, exp_marks);
  endtask

  task automatic t_flipflop();
    logic [15:0] v;
    reg_write(4'b0100, 8'hAA);
    reg_write(4'b1000, 8'h00);
    write16(4'b0100, 16'h1234);
    read16(4'b0100, v);
    chk("R2 flip-flop reset by enable write", v, 16'h1234);
  endtask

  initial begin
    rst_n = 0; cs_n = 1; rd_n = 1; wr_n = 1; a_sel = '0; db_in = '0; dreq = '0;
    nlog = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read_block();
    t_priority();
    t_disabled();
    t_hold_gate();
    t_preempt();
    t_mark();
    t_flipflop();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule